// File: doc/BRIEF.md
# Fractional Oversample Tick Generator

This block derives the 16x oversampling tick of a serial receiver/transmitter from a fast system clock. It does not count down an integer divisor. It adds a programmable increment to a phase accumulator on every clock and treats the carry out of that addition as the tick. The increment is the wanted baud rate times 2^20, divided by the system clock frequency. For a 100 MHz clock, 115200 baud needs an increment of about 1208. Because the division is fractional, the gap between ticks alternates between two adjacent whole cycle counts, and the long-run tick rate is exact.

The increment is loaded one byte at a time, through a high-byte strobe and a low-byte strobe. Software is expected to drop the enable and wait for the transmitter to go idle before it changes the rate. The block enforces that rule: a byte write that arrives while the enable is set is discarded. Dropping the enable also zeroes the accumulator, so every enabled period starts from the same phase. A second output, the bit enable, marks every sixteenth tick. The highest usable baud rate is the clock divided by 16.

Top module: `frac_baud_gen`

## Requirements
- R1: After synchronous reset the increment register is zero and both `os_tick` and `bit_en` are low.
- R2: While `uart_en` is low, `inc_hi_we` stores `inc_byte` into the upper byte of the increment (bits 2*BYTE_W-1..BYTE_W) and `inc_lo_we` stores it into the lower byte (bits BYTE_W-1..0), from the next clock on.
- R3: Byte writes presented while `uart_en` is high leave the increment unchanged.
- R4: While `uart_en` is high, each clock adds the increment to the accumulator modulo 2^(2*BYTE_W), and `os_tick` is high in the cycle after a sum that carried out. With an increment below 2^(2*BYTE_W-1), a tick is never two cycles wide.
- R5: While `uart_en` is low the accumulator is zero and `os_tick`/`bit_en` are low one cycle later. After re-enable, the first tick appears after exactly ceil(2^(2*BYTE_W)/increment) enabled cycles.
- R6: Over 2^(2*BYTE_W) enabled cycles started from a cleared accumulator, the number of ticks equals the increment exactly.
- R7: An increment of zero produces no ticks.
- R8: `bit_en` is high together with every OSR-th tick counted from enable (the OSR-th, 2*OSR-th, ...), and never without a tick.
- R9: For a nonzero increment, consecutive ticks are spaced either floor(2^(2*BYTE_W)/increment) or ceil(2^(2*BYTE_W)/increment) cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| uart_en | input | 1 | Run enable; low clears the phase and unlocks the increment |
| inc_hi_we | input | 1 | Write strobe for the increment's upper byte |
| inc_lo_we | input | 1 | Write strobe for the increment's lower byte |
| inc_byte | input | BYTE_W | Byte written by either strobe |
| os_tick | output | 1 | Oversample tick, one pulse per accumulator carry |
| bit_en | output | 1 | Bit-rate enable, every OSR-th tick |

## Verification
The bench builds the block with BYTE_W = 6 and OSR = 16, which gives a 12-bit accumulator and a full phase period of 4096 cycles. At that size the bench can run complete periods for many increments within its cycle budget: zero, one, an exact power-of-two ratio, the mid-scale boundary where ticks can start to touch, an odd fractional value and the all-ones maximum. Each period checks the exact tick count, the first-tick position and the two allowed tick spacings. A behavioural model compares both outputs with the design on every clock.

// File: rtl/frac_baud_pkg.sv
package frac_baud_pkg;

    localparam int unsigned DEF_BYTE_W = 8;
    localparam int unsigned DEF_OSR    = 16;

    typedef enum logic {
        LANE_LO = 1'b0,
        LANE_HI = 1'b1
    } lane_e;

    typedef struct packed {
        logic tick;
        logic bit_en;
    } fbg_out_t;

    function automatic int unsigned lane_base(input lane_e lane, input int unsigned byte_w);
        return int'(lane) * byte_w;
    endfunction

endpackage

// File: rtl/fbg_incr_regs.sv
module fbg_incr_regs
    import frac_baud_pkg::*;
#(
    parameter int unsigned BYTE_W = DEF_BYTE_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  lock,
    input  logic                  hi_we,
    input  logic                  lo_we,
    input  logic [BYTE_W-1:0]     wdata,
    output logic [2*BYTE_W-1:0]   inc_o
);
    localparam int unsigned LANES = 2;

    logic [LANES-1:0] lane_we;

    always_comb begin
        lane_we          = '0;
        lane_we[LANE_HI] = hi_we;
        lane_we[LANE_LO] = lo_we;
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [BYTE_W-1:0] q;

        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (!lock && lane_we[g]) begin
                q <= wdata;
            end
        end

        assign inc_o[lane_base(lane_e'(g), BYTE_W) +: BYTE_W] = q;
    end

endmodule

// File: rtl/fbg_phase_acc.sv
module fbg_phase_acc #(
    parameter int unsigned ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [ACC_W-1:0] inc,
    output logic             carry_o
);
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   sum;

    always_comb begin
        sum     = {1'b0, acc_q} + {1'b0, inc};
        carry_o = run && sum[ACC_W];
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            acc_q <= '0;
        end else begin
            acc_q <= sum[ACC_W-1:0];
        end
    end

endmodule

// File: rtl/fbg_ovs_gate.sv
module fbg_ovs_gate
    import frac_baud_pkg::*;
#(
    parameter int unsigned OSR = DEF_OSR
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     run,
    input  logic     carry,
    output fbg_out_t out_o
);
    localparam int unsigned CNT_W = (OSR > 1) ? $clog2(OSR) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);

    logic [CNT_W-1:0] cnt_q;
    fbg_out_t         out_q;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
            out_q <= '0;
        end else begin
            out_q.tick   <= carry;
            out_q.bit_en <= carry && (cnt_q == LAST);
            if (carry) begin
                cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
            end
        end
    end

    assign out_o = out_q;

endmodule

// File: rtl/frac_baud_gen.sv
module frac_baud_gen
    import frac_baud_pkg::*;
#(
    parameter int unsigned BYTE_W = DEF_BYTE_W,
    parameter int unsigned OSR    = DEF_OSR
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              uart_en,
    input  logic              inc_hi_we,
    input  logic              inc_lo_we,
    input  logic [BYTE_W-1:0] inc_byte,
    output logic              os_tick,
    output logic              bit_en
);
    localparam int unsigned INC_W = 2 * BYTE_W;

    logic [INC_W-1:0] inc_val;
    logic             carry;
    fbg_out_t         gate_out;

    fbg_incr_regs #(.BYTE_W(BYTE_W)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .lock  (uart_en),
        .hi_we (inc_hi_we),
        .lo_we (inc_lo_we),
        .wdata (inc_byte),
        .inc_o (inc_val)
    );

    fbg_phase_acc #(.ACC_W(INC_W)) u_acc (
        .clk     (clk),
        .rst     (rst),
        .run     (uart_en),
        .inc     (inc_val),
        .carry_o (carry)
    );

    fbg_ovs_gate #(.OSR(OSR)) u_gate (
        .clk   (clk),
        .rst   (rst),
        .run   (uart_en),
        .carry (carry),
        .out_o (gate_out)
    );

    assign os_tick = gate_out.tick;
    assign bit_en  = gate_out.bit_en;

endmodule

// File: rtl/frac_baud_chk.sv
module frac_baud_chk #(
    parameter int unsigned BYTE_W = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                uart_en,
    input logic                inc_hi_we,
    input logic                inc_lo_we,
    input logic [BYTE_W-1:0]   inc_byte,
    input logic                os_tick,
    input logic                bit_en,
    input logic [2*BYTE_W-1:0] inc_q
);
    localparam int unsigned INC_W = 2 * BYTE_W;

    a_r2_load_hi: assert property (@(posedge clk) disable iff (rst)
        (!uart_en && inc_hi_we) |=> inc_q[INC_W-1:BYTE_W] == $past(inc_byte));

    a_r2_load_lo: assert property (@(posedge clk) disable iff (rst)
        (!uart_en && inc_lo_we) |=> inc_q[BYTE_W-1:0] == $past(inc_byte));

    a_r3_locked: assert property (@(posedge clk) disable iff (rst)
        uart_en |=> $stable(inc_q));

    a_r4_single_wide: assert property (@(posedge clk) disable iff (rst)
        (!inc_q[INC_W-1] && os_tick) |=> !os_tick);

    a_r5_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !uart_en |=> (!os_tick && !bit_en));

    a_r7_zero_silent: assert property (@(posedge clk) disable iff (rst)
        (inc_q == '0) |-> !os_tick);

    a_r8_bit_on_tick: assert property (@(posedge clk) disable iff (rst)
        bit_en |-> os_tick);

endmodule

bind frac_baud_gen frac_baud_chk #(.BYTE_W(BYTE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .uart_en   (uart_en),
    .inc_hi_we (inc_hi_we),
    .inc_lo_we (inc_lo_we),
    .inc_byte  (inc_byte),
    .os_tick   (os_tick),
    .bit_en    (bit_en),
    .inc_q     (inc_val)
);

// File: tb/frac_baud_gen_bench.sv
module frac_baud_gen_bench;
    localparam int CLK_P  = 10;
    localparam int BW     = 6;
    localparam int OSR    = 16;
    localparam int W      = 2 * BW;
    localparam int PERIOD = 1 << W;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          uart_en = 1'b0;
    logic          inc_hi_we = 1'b0;
    logic          inc_lo_we = 1'b0;
    logic [BW-1:0] inc_byte = '0;
    logic          os_tick;
    logic          bit_en;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // behavioural reference
    int m_inc = 0, m_acc = 0, m_cnt = 0, m_sum = 0;
    bit m_tick = 1'b0, m_bit = 1'b0;

    frac_baud_gen #(.BYTE_W(BW), .OSR(OSR)) u_frac_baud_gen (
        .clk       (clk),
        .rst       (rst),
        .uart_en   (uart_en),
        .inc_hi_we (inc_hi_we),
        .inc_lo_we (inc_lo_we),
        .inc_byte  (inc_byte),
        .os_tick   (os_tick),
        .bit_en    (bit_en)
    );

    always #(CLK_P / 2) clk = ~clk;

    always @(posedge clk) begin
        if (rst) begin
            m_inc = 0; m_acc = 0; m_cnt = 0; m_tick = 0; m_bit = 0;
        end else if (!uart_en) begin
            if (inc_hi_we) m_inc = (m_inc % (1 << BW)) + int'(inc_byte) * (1 << BW);
            if (inc_lo_we) m_inc = (m_inc / (1 << BW)) * (1 << BW) + int'(inc_byte);
            m_acc = 0; m_cnt = 0; m_tick = 0; m_bit = 0;
        end else begin
            m_sum  = m_acc + m_inc;
            m_tick = (m_sum >= PERIOD);
            m_acc  = m_sum % PERIOD;
            m_bit  = m_tick && (m_cnt == OSR - 1);
            if (m_tick) m_cnt = (m_cnt + 1) % OSR;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // per-cycle comparison, away from the active edge (R4 tick, R8 bit enable)
    always @(negedge clk) begin
        if (!rst) begin
            check("R4", "tick vs model", int'(os_tick), int'(m_tick));
            check("R8", "bit_en vs model", int'(bit_en), int'(m_bit));
        end
    end

    task automatic load(input int inc);
        @(negedge clk);
        inc_hi_we = 1'b1; inc_byte = BW'(inc / (1 << BW));
        @(negedge clk);
        inc_hi_we = 1'b0; inc_lo_we = 1'b1; inc_byte = BW'(inc % (1 << BW));
        @(negedge clk);
        inc_lo_we = 1'b0;
    endtask

    task automatic window(output int nt, output int nb, output int first,
                          output int gmin, output int gmax);
        int last;
        nt = 0; nb = 0; first = -1; gmin = PERIOD + 1; gmax = -1; last = -1;
        @(negedge clk);
        uart_en = 1'b1;
        for (int c = 1; c <= PERIOD; c++) begin
            @(negedge clk);
            if (os_tick) begin
                nt++;
                if (first < 0) first = c;
                if (last >= 0) begin
                    if (c - last < gmin) gmin = c - last;
                    if (c - last > gmax) gmax = c - last;
                end
                last = c;
            end
            if (bit_en) nb++;
        end
        uart_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic full_check(input int inc);
        int nt, nb, first, gmin, gmax, lo, hi;
        window(nt, nb, first, gmin, gmax);
        check("R6", $sformatf("tick count inc=%0d", inc), nt, inc);
        check("R8", $sformatf("bit_en count inc=%0d", inc), nb, inc / OSR);
        if (inc == 0) begin
            check("R7", "no tick with zero increment", nt, 0);
        end else begin
            lo = PERIOD / inc;
            hi = (PERIOD + inc - 1) / inc;
            check("R5", $sformatf("first tick position inc=%0d", inc), first, hi);
            if (nt >= 2) begin
                check("R9", $sformatf("min gap inc=%0d", inc), int'(gmin >= lo), 1);
                check("R9", $sformatf("max gap inc=%0d", inc), int'(gmax <= hi), 1);
            end
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "tick after reset", int'(os_tick), 0);
        check("R1", "bit_en after reset", int'(bit_en), 0);
        rst = 1'b0;
        // R1: reset increment is zero, so an enabled period gives no ticks
        full_check(0);

        // R2 / R6 / R9: several increments, including boundaries
        load(1);          full_check(1);
        load(16);         full_check(16);
        load(341);        full_check(341);
        load(PERIOD / 2); full_check(PERIOD / 2);
        load(PERIOD / 2 + 1); full_check(PERIOD / 2 + 1);
        load(PERIOD - 1); full_check(PERIOD - 1);

        // R2: upper byte written alone keeps the lower byte
        @(negedge clk);
        inc_hi_we = 1'b1; inc_byte = BW'(2);
        @(negedge clk);
        inc_hi_we = 1'b0;
        full_check(2 * (1 << BW) + (PERIOD - 1) % (1 << BW));

        // R3: writes while enabled are discarded
        load(200);
        @(negedge clk);
        uart_en = 1'b1;
        inc_hi_we = 1'b1; inc_lo_we = 1'b1; inc_byte = BW'(7);
        @(negedge clk);
        inc_hi_we = 1'b0; inc_lo_we = 1'b0;
        repeat (20) @(negedge clk);
        uart_en = 1'b0;
        @(negedge clk);
        full_check(200); // R3: count still matches the value loaded while idle

        // R5: disable mid-run silences the outputs and restarts the phase
        load(341);
        @(negedge clk);
        uart_en = 1'b1;
        repeat (100) @(negedge clk);
        uart_en = 1'b0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            check("R5", "tick while disabled", int'(os_tick), 0);
            check("R5", "bit_en while disabled", int'(bit_en), 0);
        end
        full_check(341);

        // R7: zero increment again after nonzero values
        load(0); full_check(0);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule